// File: doc/BRIEF.md
# Vector Instruction Hazard Scoreboard and Dispatcher

This block sits between the scalar issue path and the two vector execution units. Each cycle it is offered at most one decoded vector instruction, made up of an operation class, two source register numbers and a destination register number. It checks that instruction against a scoreboard that holds two bits per vector register: one for an outstanding write and one for a failed write. A hazard-free instruction goes to the memory unit or to the arithmetic unit, depending on its class.

The offer uses a ready/valid handshake. While an instruction is refused, the block holds its ready output low, so the issue path keeps the instruction on its inputs until the hazard clears or the target unit accepts it. Each unit reports finished writes on its own completion port. A clean completion frees the register and clears its failed mark. A completion with an error frees the register and sets its failed mark, which prevents any later instruction from reading that register until a clean write lands.

Top module: `vec_issue_sb`

## Requirements
- R1: After reset no register is outstanding or failed, so the first instruction offered is accepted by whichever unit it targets.
- R2: Class codes 1 (load), 2 (store), 3 (gather) and 4 (scatter) go to the memory unit only. Code 0 and the unused codes 5 to 7 go to the arithmetic unit only. The other unit's valid stays low.
- R3: An instruction that writes a register (codes 0, 1, 3, 5, 6, 7) is refused while its destination has an outstanding write.
- R4: An instruction of any class is refused when either source register is marked failed.
- R5: Store (2) and scatter (4) write no register. Their destination field is ignored for hazards and marks nothing outstanding.
- R6: Accepting a register-writing instruction marks its destination outstanding from the next cycle. A completion for that register on either unit's port removes the mark from the next cycle.
- R7: A completion flagged with an error marks the register failed from the next cycle. A clean completion to that register clears the mark. A failed register may still be the destination of a new instruction.
- R8: A refused instruction drives no unit valid and keeps ready low. A hazard-free instruction whose unit is not ready drives that unit's valid with ready low. Neither case changes the scoreboard.
- R9: A completion and a dispatch in the same cycle to different registers both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction offered by issue path |
| inReady | output | 1 | Instruction accepted this cycle |
| inCls | input | 3 | Operation class code |
| inSrcA | input | 4 | First source register |
| inSrcB | input | 4 | Second source register |
| inDst | input | 4 | Destination register |
| memValid | output | 1 | Instruction offered to memory unit |
| memReady | input | 1 | Memory unit can take an instruction |
| memCls | output | 3 | Class passed to memory unit |
| memSrcA | output | 4 | First source to memory unit |
| memSrcB | output | 4 | Second source to memory unit |
| memDst | output | 4 | Destination to memory unit |
| aluValid | output | 1 | Instruction offered to arithmetic unit |
| aluReady | input | 1 | Arithmetic unit can take an instruction |
| aluSrcA | output | 4 | First source to arithmetic unit |
| aluSrcB | output | 4 | Second source to arithmetic unit |
| aluDst | output | 4 | Destination to arithmetic unit |
| memDoneValid | input | 1 | Memory unit write completion |
| memDoneReg | input | 4 | Register written by memory unit |
| memDoneErr | input | 1 | Memory unit write failed |
| aluDoneValid | input | 1 | Arithmetic unit write completion |
| aluDoneReg | input | 4 | Register written by arithmetic unit |
| aluDoneErr | input | 1 | Arithmetic unit write failed |

## Verification
The assertions check on every cycle that no unit is offered an instruction that reads a failed register or writes an outstanding one, that a claim shows up as an outstanding mark one cycle later, and that error and clean completions set and clear the failed mark. What they cannot show are sequences: a register staying blocked until its completion arrives, a failed register opening again after a clean rewrite, the destination field of stores being ignored, and a stalled instruction leaving no trace in the scoreboard. The bench's scenarios and its cycle-by-cycle model cover those.

// File: rtl/vis_pkg.sv
package vis_pkg;
  parameter int NUM_VREGS = 16;
  localparam int VREG_W = $clog2(NUM_VREGS);
  localparam int CLS_W = 3;

  localparam logic [CLS_W-1:0] CLS_ARITH   = 3'd0;
  localparam logic [CLS_W-1:0] CLS_LOAD    = 3'd1;
  localparam logic [CLS_W-1:0] CLS_STORE   = 3'd2;
  localparam logic [CLS_W-1:0] CLS_GATHER  = 3'd3;
  localparam logic [CLS_W-1:0] CLS_SCATTER = 3'd4;

  typedef struct packed {
    logic              claim;
    logic [VREG_W-1:0] claimIdx;
  } sb_strobe_t;
endpackage

// File: rtl/vis_ctrl.sv
module vis_ctrl
  import vis_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [CLS_W-1:0]     inCls,
  input  logic [VREG_W-1:0]    inSrcA,
  input  logic [VREG_W-1:0]    inSrcB,
  input  logic [VREG_W-1:0]    inDst,
  input  logic [NUM_VREGS-1:0] busyVec,
  input  logic [NUM_VREGS-1:0] corruptVec,
  input  logic                 memReady,
  input  logic                 aluReady,
  output logic                 inReady,
  output logic                 memValid,
  output logic                 aluValid,
  output sb_strobe_t           strobe
);
  logic isMem, hasDst, srcBad, dstBad, hazardFree, fire;

  always_comb begin
    isMem  = (inCls == CLS_LOAD) || (inCls == CLS_STORE) ||
             (inCls == CLS_GATHER) || (inCls == CLS_SCATTER);
    hasDst = !((inCls == CLS_STORE) || (inCls == CLS_SCATTER));
    srcBad = corruptVec[inSrcA] || corruptVec[inSrcB];
    dstBad = hasDst && busyVec[inDst];
    hazardFree = !srcBad && !dstBad;
    memValid = inValid && isMem && hazardFree;
    aluValid = inValid && !isMem && hazardFree;
    inReady  = hazardFree && (isMem ? memReady : aluReady);
    fire     = (memValid && memReady) || (aluValid && aluReady);
    strobe.claim    = fire && hasDst;
    strobe.claimIdx = inDst;
  end

  // R4
  no_corrupt_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid || aluValid) |-> (!corruptVec[inSrcA] && !corruptVec[inSrcB]));

  // R3
  no_busy_dst_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.claim |-> !busyVec[inDst]);

  // R8
  ready_needs_offer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |-> (memValid || aluValid));
endmodule

// File: rtl/vis_sb_regs.sv
module vis_sb_regs
  import vis_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  sb_strobe_t           strobe,
  input  logic                 memDoneValid,
  input  logic [VREG_W-1:0]    memDoneReg,
  input  logic                 memDoneErr,
  input  logic                 aluDoneValid,
  input  logic [VREG_W-1:0]    aluDoneReg,
  input  logic                 aluDoneErr,
  output logic [NUM_VREGS-1:0] busyVec,
  output logic [NUM_VREGS-1:0] corruptVec
);
  for (genvar i = 0; i < NUM_VREGS; i++) begin : g_entry
    logic memHit, aluHit, setHit;
    always_comb begin
      memHit = memDoneValid && (memDoneReg == VREG_W'(i));
      aluHit = aluDoneValid && (aluDoneReg == VREG_W'(i));
      setHit = strobe.claim && (strobe.claimIdx == VREG_W'(i));
    end
    always_ff @(posedge clk) begin
      if (!rstN) begin
        busyVec[i]    <= 1'b0;
        corruptVec[i] <= 1'b0;
      end else begin
        if (setHit)                busyVec[i] <= 1'b1;
        else if (memHit || aluHit) busyVec[i] <= 1'b0;
        if (memHit)                corruptVec[i] <= memDoneErr;
        else if (aluHit)           corruptVec[i] <= aluDoneErr;
      end
    end
  end

  // R6
  claim_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.claim |=> busyVec[$past(strobe.claimIdx)]);

  // R7
  err_marks_corrupt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memDoneValid && memDoneErr) |=> corruptVec[$past(memDoneReg)]);

  // R7
  clean_clears_corrupt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aluDoneValid && !aluDoneErr && !(memDoneValid && memDoneReg == aluDoneReg))
      |=> !corruptVec[$past(aluDoneReg)]);
endmodule

// File: rtl/vec_issue_sb.sv
module vec_issue_sb
  import vis_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [CLS_W-1:0]  inCls,
  input  logic [VREG_W-1:0] inSrcA,
  input  logic [VREG_W-1:0] inSrcB,
  input  logic [VREG_W-1:0] inDst,
  output logic              memValid,
  input  logic              memReady,
  output logic [CLS_W-1:0]  memCls,
  output logic [VREG_W-1:0] memSrcA,
  output logic [VREG_W-1:0] memSrcB,
  output logic [VREG_W-1:0] memDst,
  output logic              aluValid,
  input  logic              aluReady,
  output logic [VREG_W-1:0] aluSrcA,
  output logic [VREG_W-1:0] aluSrcB,
  output logic [VREG_W-1:0] aluDst,
  input  logic              memDoneValid,
  input  logic [VREG_W-1:0] memDoneReg,
  input  logic              memDoneErr,
  input  logic              aluDoneValid,
  input  logic [VREG_W-1:0] aluDoneReg,
  input  logic              aluDoneErr
);
  sb_strobe_t           strobe;
  logic [NUM_VREGS-1:0] busyVec, corruptVec;

  vis_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCls(inCls),
    .inSrcA(inSrcA), .inSrcB(inSrcB), .inDst(inDst),
    .busyVec(busyVec), .corruptVec(corruptVec),
    .memReady(memReady), .aluReady(aluReady),
    .inReady(inReady), .memValid(memValid), .aluValid(aluValid),
    .strobe(strobe)
  );

  vis_sb_regs u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .memDoneValid(memDoneValid), .memDoneReg(memDoneReg), .memDoneErr(memDoneErr),
    .aluDoneValid(aluDoneValid), .aluDoneReg(aluDoneReg), .aluDoneErr(aluDoneErr),
    .busyVec(busyVec), .corruptVec(corruptVec)
  );

  assign memCls  = inCls;
  assign memSrcA = inSrcA;
  assign memSrcB = inSrcB;
  assign memDst  = inDst;
  assign aluSrcA = inSrcA;
  assign aluSrcB = inSrcB;
  assign aluDst  = inDst;
endmodule

// File: tb/tb_vec_issue_sb.sv
module tb_vec_issue_sb;
  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 0, inReady, memValid, memReady = 0, aluValid, aluReady = 0;
  logic [2:0] inCls = 0, memCls;
  logic [3:0] inSrcA = 0, inSrcB = 0, inDst = 0;
  logic [3:0] memSrcA, memSrcB, memDst, aluSrcA, aluSrcB, aluDst;
  logic memDoneValid = 0, memDoneErr = 0, aluDoneValid = 0, aluDoneErr = 0;
  logic [3:0] memDoneReg = 0, aluDoneReg = 0;

  int checks = 0, fails = 0;
  bit busy[16];
  bit corr[16];
  bit finished = 0;

  always #2 clk = ~clk;

  vec_issue_sb dut (.*);

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s {ready,mem,alu} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(string tag, int cls, int a, int b, int d, bit mr, bit ar,
                      bit mdv = 0, int mdr = 0, bit mde = 0,
                      bit adv = 0, int adr = 0, bit ade = 0);
    bit isMem, hasDst, ok, expRdy;
    inValid = 1; inCls = 3'(cls); inSrcA = 4'(a); inSrcB = 4'(b); inDst = 4'(d);
    memReady = mr; aluReady = ar;
    memDoneValid = mdv; memDoneReg = 4'(mdr); memDoneErr = mde;
    aluDoneValid = adv; aluDoneReg = 4'(adr); aluDoneErr = ade;
    #1;
    isMem  = (cls >= 1 && cls <= 4);
    hasDst = !(cls == 2 || cls == 4);
    ok     = !corr[a] && !corr[b] && !(hasDst && busy[d]);
    expRdy = ok && (isMem ? mr : ar);
    check(tag, {inReady, memValid, aluValid}, {expRdy, isMem && ok, !isMem && ok});
    @(posedge clk);
    if (adv) begin busy[adr] = 0; corr[adr] = ade; end
    if (mdv) begin busy[mdr] = 0; corr[mdr] = mde; end
    if (expRdy && hasDst) busy[d] = 1;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state: fresh instruction accepted
    step("R1", 0, 1, 2, 3, 1, 1);
    // R3 busy destination refused, R6 completion frees it next cycle
    step("R3", 0, 4, 5, 3, 1, 1, 0, 0, 0, 1, 3, 0);
    step("R6", 0, 4, 5, 3, 1, 1);
    // R2 routing of every class code
    step("R2", 1, 0, 0, 6, 1, 1);
    step("R2", 2, 0, 0, 9, 1, 1);
    step("R2", 3, 0, 0, 7, 1, 1);
    step("R2", 4, 0, 0, 8, 1, 1);
    step("R2", 5, 0, 0, 10, 1, 1);
    step("R2", 6, 0, 0, 11, 1, 1);
    step("R2", 7, 0, 0, 12, 1, 1);
    // R5 store/scatter ignore busy destination 6 and claim none
    step("R5", 2, 1, 1, 6, 1, 1);
    step("R5", 4, 1, 1, 9, 1, 1);
    step("R5", 0, 1, 1, 9, 1, 1);
    // R7 error completion on 3 marks it failed
    step("R7", 0, 0, 0, 13, 1, 1, 0, 0, 0, 1, 3, 1);
    step("R4", 0, 3, 0, 14, 1, 1);
    step("R4", 2, 0, 3, 14, 1, 1);
    step("R7", 1, 0, 0, 3, 1, 1);
    step("R7", 0, 3, 3, 15, 1, 1, 1, 3, 0);
    step("R7", 0, 3, 3, 15, 1, 1);
    // R8 unit not ready: stall without scoreboard change
    step("R8", 1, 0, 0, 2, 0, 1);
    step("R8", 1, 0, 0, 2, 0, 1);
    step("R8", 0, 0, 0, 1, 1, 0);
    step("R8", 0, 0, 0, 2, 1, 1);
    // R9 completion of 6 and dispatch to 5 in one cycle
    step("R9", 0, 0, 0, 5, 1, 1, 1, 6, 0);
    step("R9", 1, 0, 0, 6, 1, 1);
    step("R9", 0, 0, 0, 5, 1, 1);
    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      int r = int'($urandom_range(0, 15));
      bit cmp = busy[r] && ($urandom_range(0, 2) != 0);
      bit viaMem = $urandom_range(0, 1) == 1;
      bit err = $urandom_range(0, 5) == 0;
      step("R3/R4 mixed", int'($urandom_range(0, 7)), int'($urandom_range(0, 15)),
           int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
           $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
           cmp && viaMem, r, err, cmp && !viaMem, r, err);
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule